// File: doc/BRIEF.md
# Pointer-Addressed Byte RAM with Lockable Windows

This block is a byte-organised RAM that a host can reach in two ways. The first way is a narrow port window with four byte offsets. Two offsets each load one half of a 16-bit address pointer. A third offset transfers a byte to or from the RAM location that the pointer selects. After every store through this data offset, the pointer returns to zero on its own.

The second way is a direct path. The host presents an address and an access size of one, two or four bytes. A sequencer then walks the bytes at consecutive addresses, one byte per clock. The byte at the lowest address holds the most significant part of the value. The host sees a busy flag while the walk runs, and then a single done pulse.

Two lock bits guard two fixed 16-byte windows, and the host flips each bit separately. While a window's bit is set, the window refuses writes and reads back as all ones. Addresses at or past the RAM size behave the same way.

Top module: `nvram_lockwin`

## Requirements
- R1: A write at port offset 0 replaces pointer bits 7:0, and a write at offset 1 replaces bits 15:8. In both cases the other half of the pointer keeps its value.
- R2: A write at port offset 3 stores `pt_wdata` at the pointer address when that address is accessible. The pointer becomes 0x0000 after the write, whether or not the byte was stored. A write at offset 2 has no effect.
- R3: `pt_rdata` follows `pt_sel` combinationally. For offset 3 it gives the byte at the pointer address, or 0xFF when that address is not accessible. For offsets 0, 1 and 2 it gives 0xFF. Reading never moves the pointer.
- R4: While lock bit 0 is set, addresses 0x0020 to 0x002F refuse writes from both paths and read as 0xFF. When the bit clears again, the earlier contents reappear.
- R5: While lock bit 1 is set, addresses 0x0030 to 0x003F refuse writes from both paths and read as 0xFF. This bit does not affect the window guarded by bit 0.
- R6: A cycle with `lk_tgl` high inverts lock bit `lk_idx`. The other lock bit is unchanged.
- R7: Addresses at or above `BYTES` (default 256) refuse writes and read as 0xFF on both paths.
- R8: `mm_size` selects the access width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. The N bytes sit at `mm_addr`+0 to `mm_addr`+N-1, with the address wrapping modulo 2^16. The byte at the lowest address carries the most significant byte of the value. For reads, `mm_rdata` is zero-extended and valid while `mm_done` is high.
- R9: A request seen while idle makes `mm_busy` high for exactly N cycles. `mm_done` then pulses high for one cycle, with `mm_busy` low. A request seen while busy is ignored.
- R10: While `mm_busy` is high, all port writes are ignored. This covers both pointer loads and data stores.
- R11: After reset, both lock bits are clear, the pointer is 0x0000, and `mm_busy` and `mm_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pt_sel | input | 2 | Port window byte offset |
| pt_wr | input | 1 | Port write strobe |
| pt_wdata | input | 8 | Port write data |
| pt_rdata | output | 8 | Port read data for the offset in `pt_sel` |
| lk_tgl | input | 1 | Lock bit invert strobe |
| lk_idx | input | 1 | Number of the lock bit to invert |
| mm_req | input | 1 | Direct access request |
| mm_we | input | 1 | Direct access is a write |
| mm_size | input | 2 | Direct access width code |
| mm_addr | input | 16 | Direct access start address |
| mm_wdata | input | 32 | Direct write value, right-aligned |
| mm_busy | output | 1 | Direct access sequence running |
| mm_done | output | 1 | One-cycle completion pulse |
| mm_rdata | output | 32 | Direct read value, right-aligned |

## Verification
The properties assume that every control input is a known value at each sampled edge after reset. They also assume that the host issues requests only as pulses of a few cycles. The pointer and lock properties depend on port strobes being single-cycle events. The stimulus drives all inputs from the falling edge, so no input changes near the sampling edge. It clears every strobe one cycle after raising it. Random addresses are drawn from a range that crosses both lock windows and the end of the RAM, and a directed case makes the direct path wrap past 0xFFFF.

// File: rtl/nvl_pkg.sv
package nvl_pkg;

    // Two guarded windows, 16 bytes each; base addresses are behaviour.
    localparam logic [15:0] WIN0_BASE = 16'h0020;
    localparam logic [15:0] WIN1_BASE = 16'h0030;
    localparam int          MAX_BYTES = 8192;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } nvl_size_e;

    typedef enum logic [1:0] {
        OFS_PTR_LO = 2'd0,
        OFS_PTR_HI = 2'd1,
        OFS_SPARE  = 2'd2,
        OFS_DATA   = 2'd3
    } nvl_ofs_e;

    // True when a byte address may be read or written.
    function automatic logic nvl_visible(input logic [15:0] a,
                                         input logic [1:0]  lk,
                                         input int unsigned bytes);
        logic v;
        v = (32'(a) < bytes);
        if (lk[0] && (a[15:4] == WIN0_BASE[15:4])) v = 1'b0;
        if (lk[1] && (a[15:4] == WIN1_BASE[15:4])) v = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/nvl_store.sv
module nvl_store #(
    parameter int BYTES = 256,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    // Contents are not reset: they model retained storage.
    logic [7:0] mem_q [BYTES];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/nvl_lock_gate.sv
module nvl_lock_gate
    import nvl_pkg::*;
#(
    parameter int BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tgl,
    input  logic        idx,
    input  logic [15:0] addr_a,
    input  logic [15:0] addr_b,
    output logic        vis_a,
    output logic        vis_b,
    output logic [1:0]  lock
);
    typedef struct packed {
        logic [1:0] bits;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tgl) st_d.bits[idx] = ~st_q.bits[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock  = st_q.bits;
    assign vis_a = nvl_visible(addr_a, st_q.bits, BYTES);
    assign vis_b = nvl_visible(addr_b, st_q.bits, BYTES);
endmodule

// File: rtl/nvl_port_ctl.sv
module nvl_port_ctl
    import nvl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hold,
    input  logic [1:0]  sel,
    input  logic        wr,
    input  logic [7:0]  wdata,
    output logic [15:0] ptr,
    output logic        store
);
    typedef struct packed {
        logic [15:0] ptr;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        store = 1'b0;
        if (wr && !hold) begin
            unique case (nvl_ofs_e'(sel))
                OFS_PTR_LO: st_d.ptr[7:0]  = wdata;
                OFS_PTR_HI: st_d.ptr[15:8] = wdata;
                OFS_DATA: begin
                    store    = 1'b1;
                    st_d.ptr = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/nvl_wide_seq.sv
module nvl_wide_seq
    import nvl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [1:0]  size,
    input  logic [15:0] addr,
    input  logic [31:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rdata,
    output logic [15:0] byte_addr,
    output logic        byte_we,
    output logic [7:0]  byte_wdata,
    input  logic [7:0]  byte_rdata
);
    typedef struct packed {
        logic        busy;
        logic        done;
        logic [1:0]  idx;
        logic [1:0]  last;
        logic        we;
        logic [15:0] base;
        logic [31:0] wdat;
        logic [31:0] rdat;
    } seq_t;

    seq_t st_d, st_q;
    logic [1:0] shift;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                unique case (nvl_size_e'(size))
                    SZ_BYTE: st_d.last = 2'd0;
                    SZ_HALF: st_d.last = 2'd1;
                    default: st_d.last = 2'd3;
                endcase
                st_d.we   = we;
                st_d.base = addr;
                st_d.wdat = wdata;
                st_d.rdat = '0;
            end
        end else begin
            if (!st_q.we) st_d.rdat = {st_q.rdat[23:0], byte_rdata};
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Most significant byte goes to the lowest address.
    assign shift      = st_q.last - st_q.idx;
    assign byte_addr  = st_q.base + {14'd0, st_q.idx};
    assign byte_we    = st_q.busy & st_q.we;
    assign byte_wdata = st_q.wdat[{shift, 3'b000} +: 8];
    assign busy       = st_q.busy;
    assign done       = st_q.done;
    assign rdata      = st_q.rdat;
endmodule

// File: rtl/nvram_lockwin.sv
module nvram_lockwin
    import nvl_pkg::*;
#(
    parameter int BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  pt_sel,
    input  logic        pt_wr,
    input  logic [7:0]  pt_wdata,
    output logic [7:0]  pt_rdata,
    input  logic        lk_tgl,
    input  logic        lk_idx,
    input  logic        mm_req,
    input  logic        mm_we,
    input  logic [1:0]  mm_size,
    input  logic [15:0] mm_addr,
    input  logic [31:0] mm_wdata,
    output logic        mm_busy,
    output logic        mm_done,
    output logic [31:0] mm_rdata
);
    localparam int AW = $clog2(BYTES);

    logic [15:0] ptr_q;
    logic        port_store;
    logic [1:0]  lock_q;
    logic        vis_ptr, vis_seq;
    logic [15:0] seq_addr;
    logic        seq_we;
    logic [7:0]  seq_wdata, seq_rbyte;
    logic [7:0]  ram_ptr, ram_seq;
    logic        mem_we;
    logic [15:0] mem_waddr16;
    logic [7:0]  mem_wdata;

    nvl_port_ctl u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (mm_busy),
        .sel   (pt_sel),
        .wr    (pt_wr),
        .wdata (pt_wdata),
        .ptr   (ptr_q),
        .store (port_store)
    );

    nvl_lock_gate #(.BYTES(BYTES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .tgl    (lk_tgl),
        .idx    (lk_idx),
        .addr_a (ptr_q),
        .addr_b (seq_addr),
        .vis_a  (vis_ptr),
        .vis_b  (vis_seq),
        .lock   (lock_q)
    );

    nvl_wide_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (mm_req),
        .we         (mm_we),
        .size       (mm_size),
        .addr       (mm_addr),
        .wdata      (mm_wdata),
        .busy       (mm_busy),
        .done       (mm_done),
        .rdata      (mm_rdata),
        .byte_addr  (seq_addr),
        .byte_we    (seq_we),
        .byte_wdata (seq_wdata),
        .byte_rdata (seq_rbyte)
    );

    // Single write port: the sequencer owns it while busy; the port path is held off then.
    always_comb begin
        mem_we      = 1'b0;
        mem_waddr16 = ptr_q;
        mem_wdata   = pt_wdata;
        if (seq_we) begin
            mem_we      = vis_seq;
            mem_waddr16 = seq_addr;
            mem_wdata   = seq_wdata;
        end else if (port_store) begin
            mem_we = vis_ptr;
        end
    end

    nvl_store #(.BYTES(BYTES)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr16[AW-1:0]),
        .wdata   (mem_wdata),
        .raddr_a (ptr_q[AW-1:0]),
        .rdata_a (ram_ptr),
        .raddr_b (seq_addr[AW-1:0]),
        .rdata_b (ram_seq)
    );

    assign seq_rbyte = vis_seq ? ram_seq : 8'hFF;
    assign pt_rdata  = (nvl_ofs_e'(pt_sel) == OFS_DATA && vis_ptr) ? ram_ptr : 8'hFF;
endmodule

// File: rtl/nvl_checker.sv
module nvl_checker #(
    parameter int BYTES = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  pt_sel,
    input logic        pt_wr,
    input logic [7:0]  pt_wdata,
    input logic [7:0]  pt_rdata,
    input logic        lk_tgl,
    input logic        lk_idx,
    input logic        mm_busy,
    input logic        mm_done,
    input logic [15:0] ptr,
    input logic [1:0]  lock,
    input logic        mem_we,
    input logic [15:0] mem_waddr
);
    AST_PTR_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_wr && pt_sel == 2'd0 && !mm_busy) |=>
        (ptr[7:0] == $past(pt_wdata) && ptr[15:8] == $past(ptr[15:8]))); // R1

    AST_PTR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_wr && pt_sel == 2'd3 && !mm_busy) |=> (ptr == 16'h0000)); // R2

    AST_SPARE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_sel != 2'd3) |-> (pt_rdata == 8'hFF)); // R3

    AST_WRITE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((32'(mem_waddr) < BYTES)
                    && !(lock[0] && mem_waddr >= 16'h0020 && mem_waddr <= 16'h002F)
                    && !(lock[1] && mem_waddr >= 16'h0030 && mem_waddr <= 16'h003F))); // R4 R5 R7

    AST_LOCK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_tgl |=> (lock == ($past(lock) ^ (2'b01 << $past(lk_idx))))); // R6

    AST_LOCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_tgl |=> $stable(lock)); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mm_done |-> !mm_busy); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mm_done |=> !mm_done); // R9

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mm_busy |=> $stable(ptr)); // R10
endmodule

bind nvram_lockwin nvl_checker #(.BYTES(BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pt_sel    (pt_sel),
    .pt_wr     (pt_wr),
    .pt_wdata  (pt_wdata),
    .pt_rdata  (pt_rdata),
    .lk_tgl    (lk_tgl),
    .lk_idx    (lk_idx),
    .mm_busy   (mm_busy),
    .mm_done   (mm_done),
    .ptr       (ptr_q),
    .lock      (lock_q),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr16)
);

// File: tb/nvram_lockwin_tb.sv
module nvram_lockwin_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BYTES      = 256;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pt_sel = '0;
    logic        pt_wr = 1'b0;
    logic [7:0]  pt_wdata = '0;
    logic [7:0]  pt_rdata;
    logic        lk_tgl = 1'b0;
    logic        lk_idx = 1'b0;
    logic        mm_req = 1'b0;
    logic        mm_we = 1'b0;
    logic [1:0]  mm_size = '0;
    logic [15:0] mm_addr = '0;
    logic [31:0] mm_wdata = '0;
    logic        mm_busy, mm_done;
    logic [31:0] mm_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [7:0] mdl [BYTES];
    logic [1:0] lock_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvram_lockwin #(.BYTES(BYTES)) u_dut (
        .clk(clk), .rst_n(rst_n), .pt_sel(pt_sel), .pt_wr(pt_wr),
        .pt_wdata(pt_wdata), .pt_rdata(pt_rdata), .lk_tgl(lk_tgl),
        .lk_idx(lk_idx), .mm_req(mm_req), .mm_we(mm_we), .mm_size(mm_size),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_busy(mm_busy),
        .mm_done(mm_done), .mm_rdata(mm_rdata)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic vis_m(input logic [15:0] a);
        if (32'(a) >= BYTES) return 1'b0;
        if (lock_m[0] && a >= 16'h0020 && a <= 16'h002F) return 1'b0;
        if (lock_m[1] && a >= 16'h0030 && a <= 16'h003F) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        return vis_m(a) ? mdl[a[7:0]] : 8'hFF;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic port_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        pt_sel = sel; pt_wdata = d; pt_wr = 1'b1;
        @(negedge clk);
        pt_wr = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] a);
        port_wr(2'd0, a[7:0]);
        port_wr(2'd1, a[15:8]);
    endtask

    task automatic port_store(input logic [15:0] a, input logic [7:0] d);
        set_ptr(a);
        port_wr(2'd3, d);
        if (vis_m(a)) mdl[a[7:0]] = d;
    endtask

    task automatic port_rd(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        pt_sel = sel;
        #1;
        chk(tag, {24'd0, pt_rdata}, {24'd0, exp});
    endtask

    task automatic toggle(input logic i);
        @(negedge clk);
        lk_tgl = 1'b1; lk_idx = i;
        @(negedge clk);
        lk_tgl = 1'b0;
        lock_m[i] = ~lock_m[i];
    endtask

    // Direct access; model updated and read value/cycle count checked.
    task automatic mm_op(input logic we, input logic [1:0] sz, input logic [15:0] a,
                         input logic [31:0] d, input string tag);
        int busy_n;
        int lim;
        int nb;
        logic [31:0] exp;
        nb = nbytes(sz);
        exp = '0;
        for (int i = 0; i < nb; i++) begin
            logic [15:0] ba;
            ba = a + 16'(i);
            exp = {exp[23:0], exp_byte(ba)};
        end
        @(negedge clk);
        mm_req = 1'b1; mm_we = we; mm_size = sz; mm_addr = a; mm_wdata = d;
        @(negedge clk);
        mm_req = 1'b0;
        busy_n = 0; lim = 0;
        while (!mm_done && lim < 20) begin
            if (mm_busy) busy_n++;
            lim++;
            @(negedge clk);
        end
        chk({tag, " R9 busy cycles"}, 32'(busy_n), 32'(nb));
        if (!we) chk({tag, " R8 read value"}, mm_rdata, exp);
        else begin
            for (int i = 0; i < nb; i++) begin
                logic [15:0] ba;
                ba = a + 16'(i);
                if (vis_m(ba)) mdl[ba[7:0]] = d[8*(nb-1-i) +: 8];
            end
        end
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 busy after reset", {31'd0, mm_busy}, 32'd0);
        chk("R11 done after reset", {31'd0, mm_done}, 32'd0);
        rst_n = 1'b1;
        port_rd(2'd0, 8'hFF, "R3 offset 0 reads ones");
        // R11 pointer is zero: data store lands at address 0
        port_wr(2'd3, 8'hA5);
        mdl[0] = 8'hA5;
        mm_op(1'b0, 2'd0, 16'h0000, '0, "R11 ptr zero");
        for (int a = 1; a < BYTES; a++) port_store(16'(a), 8'($urandom));
        // R11 locks clear: windows readable
        mm_op(1'b0, 2'd2, 16'h0024, '0, "R11 locks clear win0");
        mm_op(1'b0, 2'd2, 16'h0034, '0, "R11 locks clear win1");

        // R1 half loads
        set_ptr(16'h0040);
        port_wr(2'd0, 8'h41);
        port_rd(2'd3, mdl[8'h41], "R1 low half replaced");
        port_wr(2'd1, 8'h01);
        port_rd(2'd3, 8'hFF, "R1 R7 high half replaced, out of range");
        port_wr(2'd1, 8'h00);
        port_rd(2'd3, mdl[8'h41], "R1 high half kept low");
        port_rd(2'd3, mdl[8'h41], "R3 read leaves pointer");
        port_rd(2'd2, 8'hFF, "R3 offset 2 ones");
        port_rd(2'd1, 8'hFF, "R3 offset 1 ones");

        // R2 store and clear
        port_wr(2'd3, 8'h3C);
        mdl[8'h41] = 8'h3C;
        port_rd(2'd3, mdl[0], "R2 pointer cleared");
        mm_op(1'b0, 2'd0, 16'h0041, '0, "R2 stored byte");
        set_ptr(16'h0050);
        port_wr(2'd2, 8'h77);
        port_rd(2'd3, mdl[8'h50], "R2 offset 2 write no effect");

        // R4 window 0
        toggle(1'b0);
        port_store(16'h0025, 8'h77);
        set_ptr(16'h0025);
        port_rd(2'd3, 8'hFF, "R4 locked window reads ones");
        mm_op(1'b1, 2'd0, 16'h002F, 32'h0000_00EE, "R4 direct write blocked");
        mm_op(1'b0, 2'd2, 16'h002E, '0, "R4 direct read straddle");
        toggle(1'b0);
        set_ptr(16'h0025);
        port_rd(2'd3, mdl[8'h25], "R4 contents return after unlock");
        mm_op(1'b0, 2'd0, 16'h002F, '0, "R4 byte untouched");

        // R5 / R6 window 1 independent of window 0
        toggle(1'b1);
        set_ptr(16'h0025);
        port_rd(2'd3, mdl[8'h25], "R6 bit1 leaves win0 open");
        mm_op(1'b1, 2'd2, 16'h003E, 32'hA1B2C3D4, "R5 straddle write");
        mm_op(1'b0, 2'd1, 16'h003F, '0, "R5 straddle read");
        toggle(1'b0);
        mm_op(1'b0, 2'd2, 16'h002E, '0, "R6 both locked");
        toggle(1'b0);
        toggle(1'b1);
        mm_op(1'b0, 2'd2, 16'h003C, '0, "R5 R6 unlocked");

        // R7 out of range
        mm_op(1'b1, 2'd0, 16'h0100, 32'h55, "R7 write beyond size");
        mm_op(1'b0, 2'd1, 16'h00FF, '0, "R7 read across end");
        mm_op(1'b0, 2'd2, 16'hFFFE, '0, "R8 R7 address wrap");

        // R8 byte order
        mm_op(1'b1, 2'd2, 16'h0080, 32'h11223344, "R8 word write");
        set_ptr(16'h0080);
        port_rd(2'd3, 8'h11, "R8 lowest address holds msb");
        set_ptr(16'h0083);
        port_rd(2'd3, 8'h44, "R8 highest address holds lsb");
        mm_op(1'b0, 2'd1, 16'h0081, '0, "R8 half read");
        mm_op(1'b0, 2'd3, 16'h0080, '0, "R8 size 3 is word");
        mm_op(1'b1, 2'd1, 16'h0090, 32'hFFFF_BEEF, "R8 half write");
        mm_op(1'b0, 2'd2, 16'h008F, '0, "R8 half placement");

        // R9 request while busy ignored
        @(negedge clk);
        mm_req = 1'b1; mm_we = 1'b1; mm_size = 2'd2; mm_addr = 16'h00A0; mm_wdata = 32'hCAFEF00D;
        @(negedge clk);
        mm_addr = 16'h00B0; mm_wdata = 32'h0BADBEEF;
        @(negedge clk);
        mm_req = 1'b0;
        for (int i = 0; i < 4; i++) mdl[8'hA0 + i] = mm_wdata[0 +: 8] ^ mm_wdata[0 +: 8] ^ 8'(32'hCAFEF00D >> (8*(3-i)));
        begin
            int dn;
            dn = 0;
            for (int i = 0; i < 10; i++) begin
                if (mm_done) dn++;
                @(negedge clk);
            end
            chk("R9 one done pulse", 32'(dn), 32'd1);
        end
        mm_op(1'b0, 2'd2, 16'h00B0, '0, "R9 second request dropped");
        mm_op(1'b0, 2'd2, 16'h00A0, '0, "R9 first request done");

        // R10 port ignored while busy
        set_ptr(16'h0050);
        @(negedge clk);
        mm_req = 1'b1; mm_we = 1'b1; mm_size = 2'd2; mm_addr = 16'h0060; mm_wdata = 32'h01020304;
        @(negedge clk);
        mm_req = 1'b0; pt_sel = 2'd0; pt_wdata = 8'h99; pt_wr = 1'b1;
        @(negedge clk);
        pt_sel = 2'd3; pt_wdata = 8'h66;
        @(negedge clk);
        pt_wr = 1'b0;
        while (mm_busy) @(negedge clk);
        for (int i = 0; i < 4; i++) mdl[8'h60 + i] = 8'(i + 1);
        port_rd(2'd3, mdl[8'h50], "R10 pointer load ignored");
        mm_op(1'b0, 2'd0, 16'h0050, '0, "R10 data store ignored");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [15:0] a;
            logic [1:0]  sz;
            a  = 16'($urandom_range(0, 16'h013F));
            sz = 2'($urandom_range(0, 3));
            r  = $urandom;
            case ($urandom_range(0, 5))
                0: port_store(a, r[7:0]);
                1: begin
                    set_ptr(a);
                    port_rd(2'd3, exp_byte(a), "R3 R4 R5 R7 random port read");
                    port_rd(2'($urandom_range(0, 2)), 8'hFF, "R3 random spare offset");
                end
                2: toggle(r[0]);
                3, 4: mm_op(1'b0, sz, a, '0, "R8 random read");
                default: mm_op(1'b1, sz, a, r, "R8 random write");
            endcase
        end
        if (lock_m[0]) toggle(1'b0);
        if (lock_m[1]) toggle(1'b1);
        for (int a = 0; a < BYTES; a += 4) mm_op(1'b0, 2'd2, 16'(a), '0, "R8 final sweep");
        summary();
    end
endmodule